// File: doc/BRIEF.md
# Key Input to HID Reporter

This block watches four front-panel keys and turns them into a compact report the host can read, plus local control actions for use when no host is present. Each raw key line passes through a synchronizer and a debounce filter. The debounced key state is then used in three ways. It is copied into a report byte whenever the host polls. It drives local volume and mute state when the bus is not connected. It forwards a bass-boost toggle when the bus is connected.

The key roles are fixed. Key 0 raises the volume, key 1 lowers it, key 2 toggles mute and key 3 toggles bass boost. The consumer usage codes for these keys are held in a constant table in the package. A separate four-bit output register, written only by the host through a simple write port, drives four general-purpose pins that have no fixed function.

In standalone mode, the volume state is an attenuation value on a 0.5 dB scale. Zero means full level and 150 means -75 dB. One press of a volume key moves the attenuation by one 1.5 dB step.

Top module: `keypad_hid_reporter`

## Requirements
- R1: Report byte bit i (weight 1, 2, 4, 8 for i = 0..3) is 1 exactly when debounced key i is pressed; bits 7:4 are always 0. Key 0 is volume up, key 1 volume down, key 2 mute toggle, key 3 bass-boost toggle. A key line reads pressed when high (default polarity).
- R2: The package table returns usage code 0xE9, 0xEA, 0xE2, 0xE5 for keys 0, 1, 2, 3, and 0x00 for any other index.
- R3: One cycle after `poll_strobe` is high, `report_valid` is high for that one cycle and `report_data` holds the debounced bitmap; without a strobe, `report_valid` is low.
- R4: A key level change shorter than DEBOUNCE_CYCLES cycles is ignored. A press held for any longer time, including one that bounces first, produces exactly one action.
- R5: With `bus_connected` low, a volume-up press gives one `vol_up_pulse` and lowers `local_atten` by 3, saturating at 0. A volume-down press gives one `vol_dn_pulse` and raises `local_atten` by 3, saturating at 150.
- R6: With `bus_connected` low, a mute press gives one `mute_toggle` pulse and inverts `local_mute`.
- R7: With `bus_connected` low, the bass-boost key produces no `boost_toggle` pulse and leaves `local_atten` and `local_mute` unchanged.
- R8: With `bus_connected` high, the volume and mute keys produce no local pulses and leave `local_atten` and `local_mute` unchanged. A bass-boost press gives exactly one `boost_toggle` pulse.
- R9: `gpo_pins` take `gpo_wr_data` on the edge where `gpo_wr_en` is high, and hold their value otherwise, whatever the keys or the mode do.
- R10: If volume-up and volume-down presses resolve in the same cycle in standalone mode, both pulses fire and `local_atten` is unchanged.
- R11: After reset: `report_data` = 0, `report_valid` = 0, all pulses 0, `local_atten` = 30, `local_mute` = 0, `gpo_pins` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_raw | input | 4 | Raw key lines, bit i = key i |
| bus_connected | input | 1 | High when a host is attached |
| poll_strobe | input | 1 | Host request for a report |
| gpo_wr_en | input | 1 | Write enable for the output register |
| gpo_wr_data | input | 4 | Value for the output register |
| report_data | output | 8 | Debounced key bitmap report |
| report_valid | output | 1 | One-cycle report qualifier |
| vol_up_pulse | output | 1 | Standalone volume-up action |
| vol_dn_pulse | output | 1 | Standalone volume-down action |
| mute_toggle | output | 1 | Standalone mute toggle action |
| boost_toggle | output | 1 | Connected-mode bass-boost toggle |
| local_atten | output | 8 | Local attenuation in 0.5 dB units |
| local_mute | output | 1 | Local mute state |
| gpo_pins | output | 4 | Host-driven general-purpose outputs |

## Verification
The volume-up and volume-down actions can land in the same cycle. The bench provokes this by raising both key lines together, so both pass the synchronizer and debounce filter in lockstep. It then expects one pulse on each output and no change in attenuation. A host poll can also coincide with a held key pattern. Each of the sixteen patterns is polled in connected mode, and the returned byte is compared with the pattern computed in the bench.

// File: rtl/keyhid_pkg.sv
package keyhid_pkg;
   localparam int KEY_N   = 4;
   localparam int K_VUP   = 0;
   localparam int K_VDN   = 1;
   localparam int K_MUTE  = 2;
   localparam int K_BOOST = 3;

   // consumer usage codes, indexed by key number
   localparam logic [7:0] USAGE_ID [KEY_N] = '{8'hE9, 8'hEA, 8'hE2, 8'hE5};

   function automatic logic [7:0] usage_of(input int unsigned idx);
      if (idx < KEY_N) return USAGE_ID[idx[1:0]];
      return 8'h00;
   endfunction
endpackage

// File: rtl/key_conditioner.sv
module key_conditioner
   import keyhid_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DB_CYCLES   = 16,
   parameter bit ACTIVE_LOW  = 1'b0,
   localparam int CNT_W      = $clog2(DB_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KEY_N-1:0] raw,
   output logic [KEY_N-1:0] level,
   output logic [KEY_N-1:0] press
);
   logic [KEY_N-1:0] polar;

   generate
      if (ACTIVE_LOW) begin : g_inv
         assign polar = ~raw;
      end else begin : g_pass
         assign polar = raw;
      end
   endgenerate

   for (genvar k = 0; k < KEY_N; k++) begin : g_key
      logic [SYNC_STAGES-1:0] sr;
      logic [CNT_W-1:0]       cnt;
      logic                   stable;
      logic                   prev;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr     <= '0;
            cnt    <= '0;
            stable <= 1'b0;
            prev   <= 1'b0;
         end else begin
            sr   <= {sr[SYNC_STAGES-2:0], polar[k]};
            prev <= stable;
            if (sr[SYNC_STAGES-1] == stable) begin
               cnt <= '0;
            end else if (cnt == CNT_W'(DB_CYCLES - 1)) begin
               stable <= sr[SYNC_STAGES-1];
               cnt    <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end

      assign level[k] = stable;
      assign press[k] = stable & ~prev;
   end
endmodule

// File: rtl/key_action.sv
module key_action
   import keyhid_pkg::*;
#(
   parameter int ATTEN_MAX   = 150,
   parameter int ATTEN_RESET = 30,
   parameter int VOL_STEP    = 3,
   localparam int ATTEN_W    = $clog2(ATTEN_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [KEY_N-1:0]   press,
   input  logic               bus_connected,
   output logic               vol_up_pulse,
   output logic               vol_dn_pulse,
   output logic               mute_toggle,
   output logic               boost_toggle,
   output logic [ATTEN_W-1:0] local_atten,
   output logic               local_mute
);
   localparam logic [ATTEN_W-1:0] STEP_V = ATTEN_W'(VOL_STEP);
   localparam logic [ATTEN_W-1:0] MAX_V  = ATTEN_W'(ATTEN_MAX);
   localparam logic [ATTEN_W-1:0] HIGH_V = ATTEN_W'(ATTEN_MAX - VOL_STEP);

   logic [ATTEN_W-1:0] atten_up;
   logic [ATTEN_W-1:0] atten_dn;

   always_comb begin
      atten_up = (local_atten < STEP_V) ? '0 : local_atten - STEP_V;
      atten_dn = (local_atten > HIGH_V) ? MAX_V : local_atten + STEP_V;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vol_up_pulse <= 1'b0;
         vol_dn_pulse <= 1'b0;
         mute_toggle  <= 1'b0;
         boost_toggle <= 1'b0;
         local_atten  <= ATTEN_W'(ATTEN_RESET);
         local_mute   <= 1'b0;
      end else begin
         vol_up_pulse <= 1'b0;
         vol_dn_pulse <= 1'b0;
         mute_toggle  <= 1'b0;
         boost_toggle <= 1'b0;
         if (!bus_connected) begin
            vol_up_pulse <= press[K_VUP];
            vol_dn_pulse <= press[K_VDN];
            mute_toggle  <= press[K_MUTE];
            case ({press[K_VUP], press[K_VDN]})
               2'b10:   local_atten <= atten_up;
               2'b01:   local_atten <= atten_dn;
               default: local_atten <= local_atten;
            endcase
            if (press[K_MUTE]) local_mute <= ~local_mute;
         end else begin
            boost_toggle <= press[K_BOOST];
         end
      end
   end
endmodule

// File: rtl/report_port.sv
module report_port
   import keyhid_pkg::*;
#(
   parameter int REPORT_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                poll_strobe,
   input  logic [KEY_N-1:0]    level,
   output logic [REPORT_W-1:0] report_data,
   output logic                report_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         report_data  <= '0;
         report_valid <= 1'b0;
      end else begin
         report_valid <= poll_strobe;
         if (poll_strobe) report_data <= REPORT_W'(level);
      end
   end
endmodule

// File: rtl/gpo_register.sv
module gpo_register #(
   parameter int GPO_W     = 4,
   parameter int GPO_RESET = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [GPO_W-1:0] wr_data,
   output logic [GPO_W-1:0] pins
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pins <= GPO_W'(GPO_RESET);
      else if (wr_en) pins <= wr_data;
   end
endmodule

// File: rtl/keypad_hid_reporter.sv
module keypad_hid_reporter
   import keyhid_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter int DEBOUNCE_CYCLES = 16,
   parameter bit KEY_ACTIVE_LOW  = 1'b0,
   parameter int REPORT_W        = 8,
   parameter int GPO_W           = 4,
   parameter int GPO_RESET       = 0,
   parameter int ATTEN_MAX       = 150,
   parameter int ATTEN_RESET     = 30,
   parameter int VOL_STEP        = 3,
   localparam int ATTEN_W        = $clog2(ATTEN_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [KEY_N-1:0]    key_raw,
   input  logic                bus_connected,
   input  logic                poll_strobe,
   input  logic                gpo_wr_en,
   input  logic [GPO_W-1:0]    gpo_wr_data,
   output logic [REPORT_W-1:0] report_data,
   output logic                report_valid,
   output logic                vol_up_pulse,
   output logic                vol_dn_pulse,
   output logic                mute_toggle,
   output logic                boost_toggle,
   output logic [ATTEN_W-1:0]  local_atten,
   output logic                local_mute,
   output logic [GPO_W-1:0]    gpo_pins
);
   generate
      if (SYNC_STAGES < 2)                    begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
      if (DEBOUNCE_CYCLES < 1)                begin : g_bad_db    $error("DEBOUNCE_CYCLES must be at least 1"); end
      if (REPORT_W < KEY_N)                   begin : g_bad_rep   $error("REPORT_W too narrow for key bitmap"); end
      if (VOL_STEP < 1 || VOL_STEP > ATTEN_MAX) begin : g_bad_step $error("VOL_STEP out of range"); end
      if (ATTEN_RESET > ATTEN_MAX)            begin : g_bad_rst   $error("ATTEN_RESET above ATTEN_MAX"); end
   endgenerate

   logic [KEY_N-1:0] key_level;
   logic [KEY_N-1:0] key_press;

   key_conditioner #(
      .SYNC_STAGES (SYNC_STAGES),
      .DB_CYCLES   (DEBOUNCE_CYCLES),
      .ACTIVE_LOW  (KEY_ACTIVE_LOW)
   ) u_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (key_raw),
      .level (key_level),
      .press (key_press)
   );

   key_action #(
      .ATTEN_MAX   (ATTEN_MAX),
      .ATTEN_RESET (ATTEN_RESET),
      .VOL_STEP    (VOL_STEP)
   ) u_act (
      .clk           (clk),
      .rst_n         (rst_n),
      .press         (key_press),
      .bus_connected (bus_connected),
      .vol_up_pulse  (vol_up_pulse),
      .vol_dn_pulse  (vol_dn_pulse),
      .mute_toggle   (mute_toggle),
      .boost_toggle  (boost_toggle),
      .local_atten   (local_atten),
      .local_mute    (local_mute)
   );

   report_port #(
      .REPORT_W (REPORT_W)
   ) u_rep (
      .clk          (clk),
      .rst_n        (rst_n),
      .poll_strobe  (poll_strobe),
      .level        (key_level),
      .report_data  (report_data),
      .report_valid (report_valid)
   );

   gpo_register #(
      .GPO_W     (GPO_W),
      .GPO_RESET (GPO_RESET)
   ) u_gpo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (gpo_wr_en),
      .wr_data (gpo_wr_data),
      .pins    (gpo_pins)
   );
endmodule

// File: rtl/keypad_hid_reporter_chk.sv
module keypad_hid_reporter_chk
   import keyhid_pkg::*;
#(
   parameter int REPORT_W  = 8,
   parameter int GPO_W     = 4,
   parameter int ATTEN_MAX = 150,
   parameter int ATTEN_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_connected,
   input logic                poll_strobe,
   input logic                gpo_wr_en,
   input logic [GPO_W-1:0]    gpo_wr_data,
   input logic [REPORT_W-1:0] report_data,
   input logic                report_valid,
   input logic                vol_up_pulse,
   input logic                vol_dn_pulse,
   input logic                mute_toggle,
   input logic                boost_toggle,
   input logic [ATTEN_W-1:0]  local_atten,
   input logic                local_mute,
   input logic [GPO_W-1:0]    gpo_pins
);
   // R1: only the key bits may be set
   a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (report_data >> KEY_N) == '0);

   // R3: valid follows a strobe by one cycle, and only then
   a_r3_valid_after_poll: assert property (@(posedge clk) disable iff (!rst_n)
      poll_strobe |=> report_valid);
   a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !poll_strobe |=> !report_valid);

   // R5: attenuation stays in range and moves only with a volume pulse
   a_r5_atten_range: assert property (@(posedge clk) disable iff (!rst_n)
      local_atten <= ATTEN_W'(ATTEN_MAX));
   a_r5_atten_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!vol_up_pulse && !vol_dn_pulse) |-> $stable(local_atten));
   a_r5_up_lowers: assert property (@(posedge clk) disable iff (!rst_n)
      (vol_up_pulse && !vol_dn_pulse) |-> local_atten <= $past(local_atten));

   // R6: mute state changes only with a toggle pulse
   a_r6_mute_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !mute_toggle |-> $stable(local_mute));

   // R7: no boost action in standalone mode
   a_r7_no_boost_local: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_connected |=> !boost_toggle);

   // R8: no local actions while connected
   a_r8_no_local_conn: assert property (@(posedge clk) disable iff (!rst_n)
      bus_connected |=> (!vol_up_pulse && !vol_dn_pulse && !mute_toggle));

   // R9: output pins follow writes only
   a_r9_gpo_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !gpo_wr_en |=> $stable(gpo_pins));
   a_r9_gpo_load: assert property (@(posedge clk) disable iff (!rst_n)
      gpo_wr_en |=> gpo_pins == $past(gpo_wr_data));

   // R10: simultaneous up and down leave attenuation alone
   a_r10_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (vol_up_pulse && vol_dn_pulse) |-> $stable(local_atten));
endmodule

bind keypad_hid_reporter keypad_hid_reporter_chk #(
   .REPORT_W  (REPORT_W),
   .GPO_W     (GPO_W),
   .ATTEN_MAX (ATTEN_MAX),
   .ATTEN_W   (ATTEN_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_connected (bus_connected),
   .poll_strobe   (poll_strobe),
   .gpo_wr_en     (gpo_wr_en),
   .gpo_wr_data   (gpo_wr_data),
   .report_data   (report_data),
   .report_valid  (report_valid),
   .vol_up_pulse  (vol_up_pulse),
   .vol_dn_pulse  (vol_dn_pulse),
   .mute_toggle   (mute_toggle),
   .boost_toggle  (boost_toggle),
   .local_atten   (local_atten),
   .local_mute    (local_mute),
   .gpo_pins      (gpo_pins)
);

// File: tb/keypad_hid_reporter_tb.sv
`timescale 1ns/1ps
module keypad_hid_reporter_tb;
   import keyhid_pkg::*;

   localparam int SETTLE = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] key_raw = '0;
   logic       bus_connected = 1'b0;
   logic       poll_strobe = 1'b0;
   logic       gpo_wr_en = 1'b0;
   logic [3:0] gpo_wr_data = '0;
   logic [7:0] report_data;
   logic       report_valid;
   logic       vol_up_pulse, vol_dn_pulse, mute_toggle, boost_toggle;
   logic [7:0] local_atten;
   logic       local_mute;
   logic [3:0] gpo_pins;

   int n_checks = 0;
   int n_fail   = 0;
   int n_up = 0, n_dn = 0, n_mute = 0, n_boost = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   keypad_hid_reporter u_dut (
      .clk (clk), .rst_n (rst_n), .key_raw (key_raw),
      .bus_connected (bus_connected), .poll_strobe (poll_strobe),
      .gpo_wr_en (gpo_wr_en), .gpo_wr_data (gpo_wr_data),
      .report_data (report_data), .report_valid (report_valid),
      .vol_up_pulse (vol_up_pulse), .vol_dn_pulse (vol_dn_pulse),
      .mute_toggle (mute_toggle), .boost_toggle (boost_toggle),
      .local_atten (local_atten), .local_mute (local_mute),
      .gpo_pins (gpo_pins)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         n_up    <= n_up    + int'(vol_up_pulse);
         n_dn    <= n_dn    + int'(vol_dn_pulse);
         n_mute  <= n_mute  + int'(mute_toggle);
         n_boost <= n_boost + int'(boost_toggle);
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tap(input logic [3:0] mask, input int hold);
      key_raw = mask;
      cyc(hold);
      key_raw = '0;
      cyc(SETTLE);
   endtask

   task automatic poll_and_check(input int exp, input string tag);
      poll_strobe = 1'b1;
      cyc(1);
      poll_strobe = 1'b0;
      chk(report_valid == 1'b1, tag, int'(report_valid), 1);
      chk(report_data == 8'(exp), tag, int'(report_data), exp);
      cyc(1);
      chk(report_valid == 1'b0, tag, int'(report_valid), 0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      int exp_atten;
      bit exp_mute;
      int b0, b1;

      cyc(3);
      // R11 reset state
      chk(report_data == 0, "R11 report", int'(report_data), 0);
      chk(report_valid == 0, "R11 valid", int'(report_valid), 0);
      chk(local_atten == 30, "R11 atten", int'(local_atten), 30);
      chk(local_mute == 0, "R11 mute", int'(local_mute), 0);
      chk(gpo_pins == 0, "R11 gpo", int'(gpo_pins), 0);
      chk({vol_up_pulse, vol_dn_pulse, mute_toggle, boost_toggle} == 0, "R11 pulses",
          int'({vol_up_pulse, vol_dn_pulse, mute_toggle, boost_toggle}), 0);
      rst_n = 1'b1;
      cyc(2);

      // R2 usage code table
      chk(usage_of(0) == 8'hE9, "R2 key0", int'(usage_of(0)), 'hE9);
      chk(usage_of(1) == 8'hEA, "R2 key1", int'(usage_of(1)), 'hEA);
      chk(usage_of(2) == 8'hE2, "R2 key2", int'(usage_of(2)), 'hE2);
      chk(usage_of(3) == 8'hE5, "R2 key3", int'(usage_of(3)), 'hE5);
      chk(usage_of(4) == 8'h00, "R2 out of range", int'(usage_of(4)), 0);

      // R5 standalone volume up sweep down to saturation at 0
      exp_atten = 30;
      for (int i = 1; i <= 13; i++) begin
         tap(4'b0001, SETTLE);
         exp_atten = (exp_atten < 3) ? 0 : exp_atten - 3;
         chk(local_atten == 8'(exp_atten), "R5 up step", int'(local_atten), exp_atten);
         chk(n_up == i, "R5 up pulse count", n_up, i);
      end
      // R5 volume down sweep up to saturation at 150
      for (int i = 1; i <= 53; i++) begin
         tap(4'b0010, SETTLE);
         exp_atten = (exp_atten > 147) ? 150 : exp_atten + 3;
         chk(local_atten == 8'(exp_atten), "R5 down step", int'(local_atten), exp_atten);
         chk(n_dn == i, "R5 down pulse count", n_dn, i);
      end

      // R4 short glitch is ignored
      key_raw = 4'b0001; cyc(3); key_raw = '0; cyc(SETTLE);
      chk(n_up == 13, "R4 glitch pulse", n_up, 13);
      chk(local_atten == 8'(exp_atten), "R4 glitch atten", int'(local_atten), exp_atten);
      // R4 bouncing then held gives one action
      for (int i = 0; i < 8; i++) begin
         key_raw = 4'b0001; cyc(2); key_raw = '0; cyc(2);
      end
      tap(4'b0001, SETTLE);
      exp_atten -= 3;
      chk(n_up == 14, "R4 bounce pulse", n_up, 14);
      chk(local_atten == 8'(exp_atten), "R4 bounce atten", int'(local_atten), exp_atten);
      // R4 long hold gives one action
      tap(4'b0001, 600);
      exp_atten -= 3;
      chk(n_up == 15, "R4 long hold pulse", n_up, 15);
      chk(local_atten == 8'(exp_atten), "R4 long hold atten", int'(local_atten), exp_atten);

      // R6 mute toggling
      exp_mute = 1'b0;
      for (int i = 1; i <= 3; i++) begin
         tap(4'b0100, SETTLE);
         exp_mute = ~exp_mute;
         chk(local_mute == exp_mute, "R6 mute state", int'(local_mute), int'(exp_mute));
         chk(n_mute == i, "R6 mute pulse", n_mute, i);
      end

      // R7 boost key ignored standalone
      tap(4'b1000, SETTLE);
      chk(n_boost == 0, "R7 boost pulse", n_boost, 0);
      chk(local_atten == 8'(exp_atten), "R7 atten", int'(local_atten), exp_atten);
      chk(local_mute == exp_mute, "R7 mute", int'(local_mute), int'(exp_mute));

      // R10 up and down together
      tap(4'b0011, SETTLE);
      chk(n_up == 16, "R10 up pulse", n_up, 16);
      chk(n_dn == 54, "R10 down pulse", n_dn, 54);
      chk(local_atten == 8'(exp_atten), "R10 atten", int'(local_atten), exp_atten);

      // R9 output register
      gpo_wr_data = 4'hA; gpo_wr_en = 1'b1; cyc(1); gpo_wr_en = 1'b0;
      chk(gpo_pins == 4'hA, "R9 write", int'(gpo_pins), 'hA);
      gpo_wr_data = 4'h5;
      tap(4'b0111, SETTLE);
      chk(gpo_pins == 4'hA, "R9 hold", int'(gpo_pins), 'hA);
      exp_mute = ~exp_mute;

      // R1 R3 R8 connected sweep of all key patterns
      bus_connected = 1'b1;
      cyc(2);
      b0 = n_boost;
      b1 = n_up + n_dn + n_mute;
      for (int p = 0; p < 16; p++) begin
         key_raw = 4'(p);
         cyc(SETTLE);
         poll_and_check(p, "R1 R3 report bitmap");
         key_raw = '0;
         cyc(SETTLE);
      end
      poll_and_check(0, "R3 released report");
      chk(n_boost - b0 == 8, "R8 boost pulses", n_boost - b0, 8);
      chk(n_up + n_dn + n_mute == b1, "R8 no local pulses", n_up + n_dn + n_mute, b1);
      chk(local_atten == 8'(exp_atten), "R8 atten", int'(local_atten), exp_atten);
      chk(local_mute == exp_mute, "R8 mute", int'(local_mute), int'(exp_mute));
      chk(gpo_pins == 4'hA, "R9 hold connected", int'(gpo_pins), 'hA);
      cyc(2);
      chk(report_valid == 0, "R3 idle valid", int'(report_valid), 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule